// File: doc/BRIEF.md
# DMA Page Register Bank and Transfer Address Generator

This block sits beside a four-channel DMA channel engine. It keeps, for every channel, an 8-bit page register and an optional 8-bit high-page register, and software reaches both through a byte-wide port interface. The low three bits of the port offset pick the register, and a bank-select input chooses between the page bank and the high-page bank. Only four of the eight offsets reach a channel, through a fixed, non-sequential map. The other four offsets are holes: writes to them are dropped and reads of them return zero. The high-page bank can be switched off by a configuration input. While it is off, its ports neither store writes nor return data, and it adds nothing to any address.

When the channel engine needs a bus address, it raises a compute request. The request carries the channel number, the channel's current 16-bit address, a transfer position, a length and the channel's mode byte. The block joins the channel's high page (low 7 bits), its page and the current address into a 32-bit physical base, with bit 31 always zero. Bit 5 of the mode byte sets the direction. When bit 5 is clear, the result is base plus position. When it is set, the result is base minus position minus length, which is the start of a downward run. All arithmetic wraps modulo 2^32.

A two-state controller registers the result. ST_IDLE goes to ST_EMIT on a request. ST_EMIT stays in ST_EMIT while requests keep arriving, and returns to ST_IDLE when a cycle passes with no request. The address valid strobe is high exactly in ST_EMIT, one cycle after each request.

Top module: `dpa_page_addr_gen`

## Requirements
- R1: After reset every page and high-page register reads 0 and addr_vld is low.
- R2: Port offsets map to channels as 1->2, 2->3, 3->1 and 7->0; a write at a mapped offset updates only that channel's register in the bank selected by wr_hi (0 = page bank, 1 = high-page bank).
- R3: A write at offset 0, 4, 5 or 6 changes no register in either bank.
- R4: A read at offset 0, 4, 5 or 6 returns 0 in either bank.
- R5: A read at a mapped offset returns the stored 8 bits unchanged, including bit 7 of a high-page register.
- R6: While hi_page_en is 0, high-page writes are ignored and high-page reads return 0. The address uses a high page of 0. Stored high-page values are kept and become visible again once the bank is re-enabled.
- R7: With mode bit 5 clear, the address is {1'b0, highpage[6:0], page, cur} + pos, modulo 2^32.
- R8: With mode bit 5 set, the address is {1'b0, highpage[6:0], page, cur} - pos - len, modulo 2^32. Mode bits other than bit 5 have no effect.
- R9: addr_vld is high in the cycle after each cycle with cmp_req high, and then carries that request's address. It is low in the cycle after any cycle without a request, and back-to-back requests give back-to-back results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hi_page_en | input | 1 | Enables the high-page bank |
| wr_en | input | 1 | Port write strobe |
| wr_hi | input | 1 | Write bank select: 0 page, 1 high page |
| wr_off | input | 3 | Write port offset |
| wr_data | input | 8 | Write data |
| rd_hi | input | 1 | Read bank select: 0 page, 1 high page |
| rd_off | input | 3 | Read port offset |
| rd_data | output | 8 | Read data (combinational) |
| cmp_req | input | 1 | Address compute request |
| cmp_chan | input | 2 | Channel of the request |
| cmp_cur | input | 16 | Channel current address |
| cmp_pos | input | 17 | Transfer position |
| cmp_len | input | 17 | Transfer length |
| cmp_mode | input | 8 | Channel mode byte; bit 5 is the direction |
| addr_out | output | 32 | Registered physical address |
| addr_vld | output | 1 | Address valid strobe |

## Verification
All sixteen bank/offset combinations are written with distinct patterns and then read back. This separates a wrong channel map, a hole that stores data, and a bank mix-up, because each register must hold its own pattern and each hole must read zero. The address path is swept over every channel in both directions. The current address, position and length are chosen so that the sums carry into the page field and wrap below zero, and the unused mode bits are set to the opposite of bit 5, so a direction taken from the wrong bit shows up. The sweep is then repeated with the high-page bank off, which shows whether it still adds to the address, and back-to-back requests show whether the strobe and the address track each cycle.

// File: rtl/dpa_pkg.sv
package dpa_pkg;

    localparam int NCH   = 4;
    localparam int CH_W  = 2;
    localparam int OFS_W = 3;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } dpa_state_e;

    typedef struct packed {
        logic            ok;
        logic [CH_W-1:0] ch;
    } dpa_chsel_t;

    function automatic dpa_chsel_t map_offset(input logic [OFS_W-1:0] off);
        dpa_chsel_t r;
        r.ok = 1'b1;
        r.ch = '0;
        unique case (off)
            3'd1:    r.ch = 2'd2;
            3'd2:    r.ch = 2'd3;
            3'd3:    r.ch = 2'd1;
            3'd7:    r.ch = 2'd0;
            default: r.ok = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/dpa_port_decode.sv
module dpa_port_decode
    import dpa_pkg::*;
(
    input  logic [OFS_W-1:0] off,
    output logic             ok,
    output logic [CH_W-1:0]  ch
);
    dpa_chsel_t sel;

    always_comb begin
        sel = map_offset(off);
        ok  = sel.ok;
        ch  = sel.ch;
    end
endmodule

// File: rtl/dpa_page_bank.sv
module dpa_page_bank
    import dpa_pkg::*;
#(
    parameter int W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  we,
    input  logic [CH_W-1:0]       wch,
    input  logic [W-1:0]          wdata,
    output logic [NCH-1:0][W-1:0] regs
);
    for (genvar g = 0; g < NCH; g++) begin : g_ch
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                regs[g] <= '0;
            else if (we && (wch == CH_W'(g)))
                regs[g] <= wdata;
        end

        a_r2_only_selected: assert property (@(posedge clk) disable iff (!rst_n)
            (we && (wch != CH_W'(g))) |=> $stable(regs[g]));
    end

    a_r3_no_write_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(regs));
endmodule

// File: rtl/dpa_addr_calc.sv
module dpa_addr_calc #(
    parameter int OFF_W  = 16,
    parameter int PAGE_W = 8,
    parameter int HPG_W  = 7,
    parameter int LEN_W  = 17,
    parameter int DIR_B  = 5,
    localparam int ADDR_W = 1 + HPG_W + PAGE_W + OFF_W
) (
    input  logic [PAGE_W-1:0] hpage,
    input  logic              hpage_en,
    input  logic [PAGE_W-1:0] page,
    input  logic [OFF_W-1:0]  cur,
    input  logic [LEN_W-1:0]  pos,
    input  logic [LEN_W-1:0]  len,
    input  logic [7:0]        mode,
    output logic [ADDR_W-1:0] addr
);
    logic [HPG_W-1:0]  hp_eff;
    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] pos_x;
    logic [ADDR_W-1:0] len_x;
    logic              down;
    logic              unused_bits;

    always_comb begin
        hp_eff      = hpage_en ? hpage[HPG_W-1:0] : '0;
        base        = {1'b0, hp_eff, page, cur};
        pos_x       = {{(ADDR_W-LEN_W){1'b0}}, pos};
        len_x       = {{(ADDR_W-LEN_W){1'b0}}, len};
        down        = mode[DIR_B];
        addr        = down ? (base - pos_x - len_x) : (base + pos_x);
        unused_bits = ^{mode, hpage};
    end
endmodule

// File: rtl/dpa_page_addr_gen.sv
module dpa_page_addr_gen
    import dpa_pkg::*;
#(
    parameter int OFF_W  = 16,
    parameter int PAGE_W = 8,
    parameter int HPG_W  = 7,
    parameter int LEN_W  = 17,
    localparam int ADDR_W = 1 + HPG_W + PAGE_W + OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hi_page_en,
    input  logic              wr_en,
    input  logic              wr_hi,
    input  logic [OFS_W-1:0]  wr_off,
    input  logic [PAGE_W-1:0] wr_data,
    input  logic              rd_hi,
    input  logic [OFS_W-1:0]  rd_off,
    output logic [PAGE_W-1:0] rd_data,
    input  logic              cmp_req,
    input  logic [CH_W-1:0]   cmp_chan,
    input  logic [OFF_W-1:0]  cmp_cur,
    input  logic [LEN_W-1:0]  cmp_pos,
    input  logic [LEN_W-1:0]  cmp_len,
    input  logic [7:0]        cmp_mode,
    output logic [ADDR_W-1:0] addr_out,
    output logic              addr_vld
);
    logic                       wr_ok, rd_ok;
    logic [CH_W-1:0]            wr_ch, rd_ch;
    logic                       lo_we, hi_we;
    logic [NCH-1:0][PAGE_W-1:0] lo_q, hi_q;
    logic [ADDR_W-1:0]          addr_d;
    dpa_state_e                 state_q, state_d;

    dpa_port_decode u_wdec (.off(wr_off), .ok(wr_ok), .ch(wr_ch));
    dpa_port_decode u_rdec (.off(rd_off), .ok(rd_ok), .ch(rd_ch));

    assign lo_we = wr_en && wr_ok && !wr_hi;
    assign hi_we = wr_en && wr_ok && wr_hi && hi_page_en;

    dpa_page_bank #(.W(PAGE_W)) u_lo (
        .clk(clk), .rst_n(rst_n), .we(lo_we), .wch(wr_ch),
        .wdata(wr_data), .regs(lo_q)
    );

    dpa_page_bank #(.W(PAGE_W)) u_hi (
        .clk(clk), .rst_n(rst_n), .we(hi_we), .wch(wr_ch),
        .wdata(wr_data), .regs(hi_q)
    );

    always_comb begin
        rd_data = '0;
        if (rd_ok) begin
            if (!rd_hi)
                rd_data = lo_q[rd_ch];
            else if (hi_page_en)
                rd_data = hi_q[rd_ch];
        end
    end

    dpa_addr_calc #(
        .OFF_W(OFF_W), .PAGE_W(PAGE_W), .HPG_W(HPG_W), .LEN_W(LEN_W)
    ) u_calc (
        .hpage(hi_q[cmp_chan]), .hpage_en(hi_page_en), .page(lo_q[cmp_chan]),
        .cur(cmp_cur), .pos(cmp_pos), .len(cmp_len), .mode(cmp_mode),
        .addr(addr_d)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (cmp_req)  state_d = ST_EMIT;
            ST_EMIT: if (!cmp_req) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            addr_out <= '0;
        else if (cmp_req)
            addr_out <= addr_d;
    end

    assign addr_vld = (state_q == ST_EMIT);

    a_r9_vld_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_req |=> addr_vld);
    a_r9_vld_drops: assert property (@(posedge clk) disable iff (!rst_n)
        !cmp_req |=> !addr_vld);
    a_r9_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
        !cmp_req |=> $stable(addr_out));
    a_r6_hi_off_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_hi && !hi_page_en) |=> $stable(hi_q));
    a_r3_hole_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_ok) |=> ($stable(lo_q) && $stable(hi_q)));
    a_r4_hole_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_ok |-> (rd_data == '0));
    a_r7_top_bit_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_vld && !$past(cmp_mode[5])) |-> !addr_out[ADDR_W-1] || $past(cmp_pos) != '0);
endmodule

// File: tb/sim_dpa_page_addr_gen.sv
module sim_dpa_page_addr_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hi_page_en = 1'b1;
    logic        wr_en = 1'b0, wr_hi = 1'b0;
    logic [2:0]  wr_off = '0;
    logic [7:0]  wr_data = '0;
    logic        rd_hi = 1'b0;
    logic [2:0]  rd_off = '0;
    logic [7:0]  rd_data;
    logic        cmp_req = 1'b0;
    logic [1:0]  cmp_chan = '0;
    logic [15:0] cmp_cur = '0;
    logic [16:0] cmp_pos = '0, cmp_len = '0;
    logic [7:0]  cmp_mode = '0;
    logic [31:0] addr_out;
    logic        addr_vld;

    int n_chk = 0, n_bad = 0;
    logic [7:0] m_lo [4];
    logic [7:0] m_hi [4];

    always #10 clk = ~clk;

    dpa_page_addr_gen u0 (
        .clk(clk), .rst_n(rst_n), .hi_page_en(hi_page_en),
        .wr_en(wr_en), .wr_hi(wr_hi), .wr_off(wr_off), .wr_data(wr_data),
        .rd_hi(rd_hi), .rd_off(rd_off), .rd_data(rd_data),
        .cmp_req(cmp_req), .cmp_chan(cmp_chan), .cmp_cur(cmp_cur),
        .cmp_pos(cmp_pos), .cmp_len(cmp_len), .cmp_mode(cmp_mode),
        .addr_out(addr_out), .addr_vld(addr_vld)
    );

    function automatic int chan_of(input int off);
        case (off)
            1: return 2;
            2: return 3;
            3: return 1;
            7: return 0;
            default: return -1;
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic port_write(input logic hi, input int off, input logic [7:0] d);
        int c;
        @(negedge clk);
        wr_en = 1'b1; wr_hi = hi; wr_off = off[2:0]; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        c = chan_of(off);
        if (c >= 0) begin
            if (!hi) m_lo[c] = d;
            else if (hi_page_en) m_hi[c] = d;
        end
    endtask

    task automatic read_all(input string req);
        for (int b = 0; b < 2; b++) begin
            for (int o = 0; o < 8; o++) begin
                int c;
                logic [7:0] e;
                rd_hi = b[0]; rd_off = o[2:0];
                #1;
                c = chan_of(o);
                e = 8'h00;
                if (c >= 0) begin
                    if (b == 0) e = m_lo[c];
                    else if (hi_page_en) e = m_hi[c];
                end
                check(req, {24'h0, rd_data}, {24'h0, e});
            end
        end
    endtask

    function automatic logic [31:0] exp_addr(input int c, input logic [15:0] cur,
                                             input logic [16:0] pos, input logic [16:0] len,
                                             input logic dn);
        logic [31:0] base;
        logic [6:0]  hp;
        hp   = hi_page_en ? m_hi[c][6:0] : 7'h0;
        base = {1'b0, hp, m_lo[c], cur};
        if (dn) return base - {15'h0, pos} - {15'h0, len};
        return base + {15'h0, pos};
    endfunction

    task automatic compute(input int c, input logic [15:0] cur, input logic [16:0] pos,
                           input logic [16:0] len, input logic dn);
        logic [31:0] e;
        @(negedge clk);
        cmp_req = 1'b1; cmp_chan = c[1:0]; cmp_cur = cur; cmp_pos = pos; cmp_len = len;
        cmp_mode = dn ? 8'h20 : 8'hDF;
        e = exp_addr(c, cur, pos, len, dn);
        @(negedge clk);
        cmp_req = 1'b0;
        check("R9 valid", {31'h0, addr_vld}, 32'h1);
        check(dn ? "R8 down address" : "R7 up address", addr_out, e);
        @(negedge clk);
        check("R9 valid drop", {31'h0, addr_vld}, 32'h0);
    endtask

    task automatic sweep();
        logic [15:0] curs [4];
        logic [16:0] poss [4];
        logic [16:0] lens [4];
        curs[0] = 16'h1234; poss[0] = 17'h00010; lens[0] = 17'h00100;
        curs[1] = 16'hFFFF; poss[1] = 17'h00005; lens[1] = 17'h00001;
        curs[2] = 16'h0000; poss[2] = 17'h00000; lens[2] = 17'h00001;
        curs[3] = 16'h8000; poss[3] = 17'h0FFFF; lens[3] = 17'h10000;
        for (int c = 0; c < 4; c++)
            for (int d = 0; d < 2; d++)
                for (int k = 0; k < 4; k++)
                    compute(c, curs[k], poss[k], lens[k], d[0]);
    endtask

    initial begin
        #2000000;
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4; i++) begin m_lo[i] = 8'h0; m_hi[i] = 8'h0; end
        #45 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 vld after reset", {31'h0, addr_vld}, 32'h0);
        read_all("R1 reset read");

        // R2 R3 R5: fill every offset in both banks, including holes
        for (int b = 0; b < 2; b++)
            for (int o = 0; o < 8; o++)
                port_write(b[0], o, 8'h81 ^ 8'(o * 8'h13) ^ (b != 0 ? 8'h6C : 8'h00));
        read_all("R2 R3 R4 R5 bank readback");

        // R3 holes after data present: writes to holes must not disturb channels
        port_write(1'b0, 0, 8'hEE);
        port_write(1'b1, 5, 8'hEE);
        read_all("R3 hole writes");

        sweep();

        // R9 back-to-back
        @(negedge clk);
        cmp_req = 1'b1; cmp_chan = 2'd1; cmp_cur = 16'h4000; cmp_pos = 17'd7; cmp_len = 17'd0; cmp_mode = 8'h00;
        @(negedge clk);
        check("R9 b2b valid 1", {31'h0, addr_vld}, 32'h1);
        check("R9 b2b addr 1", addr_out, exp_addr(1, 16'h4000, 17'd7, 17'd0, 1'b0));
        cmp_chan = 2'd2; cmp_cur = 16'h0010; cmp_pos = 17'd3; cmp_len = 17'd4; cmp_mode = 8'h20;
        @(negedge clk);
        check("R9 b2b valid 2", {31'h0, addr_vld}, 32'h1);
        check("R9 b2b addr 2", addr_out, exp_addr(2, 16'h0010, 17'd3, 17'd4, 1'b1));
        cmp_req = 1'b0;
        @(negedge clk);
        check("R9 b2b drop", {31'h0, addr_vld}, 32'h0);

        // R6 high bank disabled
        hi_page_en = 1'b0;
        port_write(1'b1, 7, 8'h3C);
        port_write(1'b1, 1, 8'h3C);
        read_all("R6 disabled reads");
        sweep();
        hi_page_en = 1'b1;
        read_all("R6 values kept after re-enable");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule